// File: doc/BRIEF.md
# Multithreaded Fetch Queue with Squash

This block is a circular instruction queue shared by several hardware threads. A front end first claims a slot for a thread (a reservation), and later fills the oldest claimed slot with an instruction tag. The reservation counts toward occupancy, so the front end can check for space before the instruction data exists. A downstream consumer takes entries from the head in the order they were written.

When a thread's speculative path is thrown away, a squash marks that thread's stored entries as dead. A global squash marks every stored entry. Dead entries stay in their slots and keep using storage until the consumer pulls them. The consumer sees a squashed flag on the head entry and can discard it. Reservations of the squashed threads are cancelled.

The queue keeps valid, reserved and squashed counts for each thread and in total, as well as the combined occupancy and a full flag. Depth and thread count are parameters, and the depth must be a power of two.

Top module: `fetch_queue_mt`

## Requirements
- R1: After reset all counts, the occupancy, `full` and `out_avail` are zero.
- R2: A reserve for thread t is accepted only while occupancy is below DEPTH. When accepted, the total reserved count and thread t's reserved count each rise by one. A reserve while `full` is high has no effect.
- R3: An append for thread t is accepted only if thread t has at least one outstanding reservation. It writes the tag and thread ID at the tail with the squashed flag clear. The reserved count falls by one and the valid count rises by one, both for t and in total. An append for a thread with no reservation has no effect.
- R4: `out_avail` is high whenever stored (valid or squashed) entries exist, and `out_tag`/`out_tid`/`out_squashed` show the head entry in the same cycle. A pull removes the head entry and lowers the valid count of its thread (or the squashed count if it was squashed). A pull on an empty queue has no effect.
- R5: Entries leave in the order they were appended. This holds across any number of wraps of the head and tail indices.
- R6: A global squash (`sq_all`) marks every stored entry squashed. It moves every thread's valid count into its squashed count and sets all reserved counts to zero.
- R7: A per-thread squash (`sq_one` with `sq_tid`=t) marks only thread t's stored entries. It moves t's valid count into t's squashed count and clears t's reservations from its own count and from the total. Other threads' counts are unchanged.
- R8: `occupancy` equals total valid + reserved + squashed. `full` is high exactly when it equals DEPTH.
- R9: A reserve, an append and a pull in the same cycle all take effect together, with every count updated consistently.
- R10: In a cycle with `sq_all` or `sq_one` high, any reserve, append or pull request is ignored.
- R11: Each total count equals the sum of the per-thread counts. Thread t's counts sit at bits [t*CNT_W +: CNT_W] of `val_thr`, `rsv_thr` and `sq_thr`.
- R12: An entry appended after a squash is delivered with `out_squashed` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rsv_req | input | 1 | Reserve one slot |
| rsv_tid | input | TID_W | Thread of the reservation |
| app_req | input | 1 | Append an instruction into a reserved slot |
| app_tid | input | TID_W | Thread of the appended instruction |
| app_tag | input | TAG_W | Instruction tag written at the tail |
| pull_req | input | 1 | Remove the head entry |
| sq_all | input | 1 | Squash every stored entry and reservation |
| sq_one | input | 1 | Squash the entries and reservations of one thread |
| sq_tid | input | TID_W | Thread targeted by `sq_one` |
| out_avail | output | 1 | Head entry present |
| out_tag | output | TAG_W | Tag of the head entry |
| out_tid | output | TID_W | Thread of the head entry |
| out_squashed | output | 1 | Head entry is dead |
| occupancy | output | CNT_W | Valid + reserved + squashed |
| full | output | 1 | Occupancy equals DEPTH |
| val_total | output | CNT_W | Total valid entries |
| rsv_total | output | CNT_W | Total outstanding reservations |
| sq_total | output | CNT_W | Total squashed entries still stored |
| val_thr | output | NTHREADS*CNT_W | Per-thread valid counts |
| rsv_thr | output | NTHREADS*CNT_W | Per-thread reserved counts |
| sq_thr | output | NTHREADS*CNT_W | Per-thread squashed counts |

## Verification
The checks assume that thread IDs on `rsv_tid`, `app_tid` and `sq_tid` are below NTHREADS. They also assume that DEPTH is a power of two, so the counters never leave their width. The stimulus only produces in-range thread IDs and uses the default depth. Illegal requests, such as a pull when empty, a reserve when full, an append with no reservation, or a request during a squash, are sent on purpose. They are legal inputs that the block must drop, and the assertions expect them to leave the counts consistent.

// File: rtl/fq_pkg.sv
package fq_pkg;

  // Counter step used by every per-thread and total counter.
  function automatic int unsigned fq_bump(int unsigned cnt, bit inc, bit dec);
    return cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // Depth legality: a power of two of at least two.
  function automatic bit fq_depth_ok(int depth);
    return (depth >= 2) && ((depth & (depth - 1)) == 0);
  endfunction

endpackage

// File: rtl/fq_ptrs.sv
module fq_ptrs #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_head,
  input  logic          adv_tail,
  output logic [PW-1:0] head_idx,
  output logic [PW-1:0] tail_idx,
  output logic [PW:0]   stored
);
  // One extra wrap bit beyond the index lets full and empty be told apart.
  logic [PW:0] head_q, tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (adv_head) head_q <= head_q + (PW+1)'(1);
      if (adv_tail) tail_q <= tail_q + (PW+1)'(1);
    end
  end

  assign head_idx = head_q[PW-1:0];
  assign tail_idx = tail_q[PW-1:0];
  assign stored   = tail_q - head_q;
endmodule

// File: rtl/fq_store.sv
module fq_store #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int TAG_W = 16,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             kill_all,
  input  logic             kill_one,
  input  logic [TID_W-1:0] kill_tid,
  input  logic [PW-1:0]    rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TID_W-1:0] rd_tid,
  output logic             rd_dead
);
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [TID_W-1:0] tid_q  [DEPTH];
  logic             dead_q [DEPTH];

  // Squash marks every slot whose thread matches. Slots outside the
  // head..tail window are rewritten with a clear flag before use, so
  // marking them is harmless and saves a range comparator per slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        tag_q[e]  <= '0;
        tid_q[e]  <= '0;
        dead_q[e] <= 1'b0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_en && (wr_idx == PW'(e))) begin
          tag_q[e]  <= wr_tag;
          tid_q[e]  <= wr_tid;
          dead_q[e] <= 1'b0;
        end else if (kill_all || (kill_one && (tid_q[e] == kill_tid))) begin
          dead_q[e] <= 1'b1;
        end
      end
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_tid  = tid_q[rd_idx];
  assign rd_dead = dead_q[rd_idx];
endmodule

// File: rtl/fq_thread_ctr.sv
module fq_thread_ctr
  import fq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsv_inc,
  input  logic             app_inc,
  input  logic             pull_live,
  input  logic             pull_dead,
  input  logic             kill,
  output logic [CNT_W-1:0] val_cnt,
  output logic [CNT_W-1:0] rsv_cnt,
  output logic [CNT_W-1:0] dead_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_cnt  <= '0;
      rsv_cnt  <= '0;
      dead_cnt <= '0;
    end else if (kill) begin
      dead_cnt <= dead_cnt + val_cnt;
      val_cnt  <= '0;
      rsv_cnt  <= '0;
    end else begin
      val_cnt  <= CNT_W'(fq_bump(int'(val_cnt), app_inc, pull_live));
      rsv_cnt  <= CNT_W'(fq_bump(int'(rsv_cnt), rsv_inc, app_inc));
      dead_cnt <= CNT_W'(fq_bump(int'(dead_cnt), 1'b0, pull_dead));
    end
  end
endmodule

// File: rtl/fetch_queue_mt.sv
module fetch_queue_mt
  import fq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NTHREADS = 4,
  parameter int TAG_W    = 16,
  parameter int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rsv_req,
  input  logic [TID_W-1:0]          rsv_tid,
  input  logic                      app_req,
  input  logic [TID_W-1:0]          app_tid,
  input  logic [TAG_W-1:0]          app_tag,
  input  logic                      pull_req,
  input  logic                      sq_all,
  input  logic                      sq_one,
  input  logic [TID_W-1:0]          sq_tid,
  output logic                      out_avail,
  output logic [TAG_W-1:0]          out_tag,
  output logic [TID_W-1:0]          out_tid,
  output logic                      out_squashed,
  output logic [CNT_W-1:0]          occupancy,
  output logic                      full,
  output logic [CNT_W-1:0]          val_total,
  output logic [CNT_W-1:0]          rsv_total,
  output logic [CNT_W-1:0]          sq_total,
  output logic [NTHREADS*CNT_W-1:0] val_thr,
  output logic [NTHREADS*CNT_W-1:0] rsv_thr,
  output logic [NTHREADS*CNT_W-1:0] sq_thr
);
  localparam int PW = $clog2(DEPTH);

  if (!fq_depth_ok(DEPTH)) begin : g_bad_depth
    $error("fetch_queue_mt: DEPTH must be a power of two");
  end

  // Per-thread counter values.
  logic [CNT_W-1:0] val_c [NTHREADS];
  logic [CNT_W-1:0] rsv_c [NTHREADS];
  logic [CNT_W-1:0] sq_c  [NTHREADS];

  // Named events, also seen by the checker.
  logic sq_any, rsv_fire, app_fire, pull_fire, pull_live, pull_dead;
  logic app_has_rsv;

  logic [PW-1:0]    head_idx, tail_idx;
  logic [PW:0]      stored;
  logic [TAG_W-1:0] head_tag;
  logic [TID_W-1:0] head_tid;
  logic             head_dead;

  logic [CNT_W-1:0] val_tot_q, rsv_tot_q, sq_tot_q;
  logic [CNT_W-1:0] kill_val, kill_rsv;

  assign sq_any      = sq_all | sq_one;
  assign app_has_rsv = (int'(app_tid) < NTHREADS) && (rsv_c[app_tid] != '0);
  assign rsv_fire    = rsv_req  & ~full & ~sq_any;
  assign app_fire    = app_req  & app_has_rsv & ~sq_any;
  assign pull_fire   = pull_req & (stored != '0) & ~sq_any;
  assign pull_live   = pull_fire & ~head_dead;
  assign pull_dead   = pull_fire &  head_dead;

  fq_ptrs #(.DEPTH(DEPTH), .PW(PW)) ptrs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_head (pull_fire),
    .adv_tail (app_fire),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .stored   (stored)
  );

  fq_store #(.DEPTH(DEPTH), .PW(PW), .TAG_W(TAG_W), .TID_W(TID_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (app_fire),
    .wr_idx   (tail_idx),
    .wr_tag   (app_tag),
    .wr_tid   (app_tid),
    .kill_all (sq_all),
    .kill_one (sq_one),
    .kill_tid (sq_tid),
    .rd_idx   (head_idx),
    .rd_tag   (head_tag),
    .rd_tid   (head_tid),
    .rd_dead  (head_dead)
  );

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    logic is_rsv, is_app, is_head, is_kill;
    assign is_rsv  = rsv_fire && (rsv_tid  == TID_W'(t));
    assign is_app  = app_fire && (app_tid  == TID_W'(t));
    assign is_head = head_tid == TID_W'(t);
    assign is_kill = sq_all || (sq_one && (sq_tid == TID_W'(t)));

    fq_thread_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsv_inc   (is_rsv),
      .app_inc   (is_app),
      .pull_live (pull_live & is_head),
      .pull_dead (pull_dead & is_head),
      .kill      (is_kill),
      .val_cnt   (val_c[t]),
      .rsv_cnt   (rsv_c[t]),
      .dead_cnt  (sq_c[t])
    );

    assign val_thr[t*CNT_W +: CNT_W] = val_c[t];
    assign rsv_thr[t*CNT_W +: CNT_W] = rsv_c[t];
    assign sq_thr[t*CNT_W +: CNT_W]  = sq_c[t];
  end

  // Totals are kept in their own registers and cross-checked against the
  // per-thread sums by the checker.
  assign kill_val = sq_all ? val_tot_q : val_c[sq_tid];
  assign kill_rsv = sq_all ? rsv_tot_q : rsv_c[sq_tid];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_tot_q <= '0;
      rsv_tot_q <= '0;
      sq_tot_q  <= '0;
    end else if (sq_any) begin
      val_tot_q <= val_tot_q - kill_val;
      rsv_tot_q <= rsv_tot_q - kill_rsv;
      sq_tot_q  <= sq_tot_q + kill_val;
    end else begin
      val_tot_q <= CNT_W'(fq_bump(int'(val_tot_q), app_fire, pull_live));
      rsv_tot_q <= CNT_W'(fq_bump(int'(rsv_tot_q), rsv_fire, app_fire));
      sq_tot_q  <= CNT_W'(fq_bump(int'(sq_tot_q), 1'b0, pull_dead));
    end
  end

  assign occupancy    = CNT_W'(stored) + rsv_tot_q;
  assign full         = occupancy == CNT_W'(DEPTH);
  assign val_total    = val_tot_q;
  assign rsv_total    = rsv_tot_q;
  assign sq_total     = sq_tot_q;
  assign out_avail    = stored != '0;
  assign out_tag      = head_tag;
  assign out_tid      = head_tid;
  assign out_squashed = head_dead;
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int DEPTH    = 8,
  parameter int NTHREADS = 4,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sq_all,
  input logic                      sq_one,
  input logic                      full,
  input logic                      out_avail,
  input logic                      rsv_fire,
  input logic [CNT_W-1:0]          occupancy,
  input logic [CNT_W-1:0]          val_total,
  input logic [CNT_W-1:0]          rsv_total,
  input logic [CNT_W-1:0]          sq_total,
  input logic [NTHREADS*CNT_W-1:0] val_thr,
  input logic [NTHREADS*CNT_W-1:0] rsv_thr,
  input logic [NTHREADS*CNT_W-1:0] sq_thr
);
  function automatic int field_sum(logic [NTHREADS*CNT_W-1:0] v);
    int s = 0;
    for (int t = 0; t < NTHREADS; t++) s += int'(v[t*CNT_W +: CNT_W]);
    return s;
  endfunction

  int stored_now;
  assign stored_now = int'(val_total) + int'(sq_total);

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH);

  // R8
  occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) == stored_now + int'(rsv_total));

  // R2
  reserve_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_fire |-> !full);

  // R11
  val_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_sum(val_thr) == int'(val_total));

  // R11
  rsv_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_sum(rsv_thr) == int'(rsv_total));

  // R11
  sq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_sum(sq_thr) == int'(sq_total));

  // R6
  squash_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_all |=> (val_total == '0) && (rsv_total == '0));

  // R10
  squash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_all || sq_one) |=> stored_now == $past(stored_now));

  // R4
  empty_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_avail |-> (val_total == '0) && (sq_total == '0));
endmodule

bind fetch_queue_mt fq_checker #(.DEPTH(DEPTH), .NTHREADS(NTHREADS), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sq_all    (sq_all),
  .sq_one    (sq_one),
  .full      (full),
  .out_avail (out_avail),
  .rsv_fire  (rsv_fire),
  .occupancy (occupancy),
  .val_total (val_total),
  .rsv_total (rsv_total),
  .sq_total  (sq_total),
  .val_thr   (val_thr),
  .rsv_thr   (rsv_thr),
  .sq_thr    (sq_thr)
);

// File: tb/fetch_queue_mt_tb_top.sv
`timescale 1ns/1ps
module fetch_queue_mt_tb_top;
  localparam int DEPTH = 8, NT = 4, TAG_W = 16, TID_W = 2, CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsv_req = 0, app_req = 0, pull_req = 0, sq_all = 0, sq_one = 0;
  logic [TID_W-1:0] rsv_tid = '0, app_tid = '0, sq_tid = '0;
  logic [TAG_W-1:0] app_tag = '0;
  logic out_avail, out_squashed, full;
  logic [TAG_W-1:0] out_tag;
  logic [TID_W-1:0] out_tid;
  logic [CNT_W-1:0] occupancy, val_total, rsv_total, sq_total;
  logic [NT*CNT_W-1:0] val_thr, rsv_thr, sq_thr;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  fetch_queue_mt #(.DEPTH(DEPTH), .NTHREADS(NT), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rsv_req(rsv_req), .rsv_tid(rsv_tid),
    .app_req(app_req), .app_tid(app_tid), .app_tag(app_tag),
    .pull_req(pull_req), .sq_all(sq_all), .sq_one(sq_one), .sq_tid(sq_tid),
    .out_avail(out_avail), .out_tag(out_tag), .out_tid(out_tid),
    .out_squashed(out_squashed), .occupancy(occupancy), .full(full),
    .val_total(val_total), .rsv_total(rsv_total), .sq_total(sq_total),
    .val_thr(val_thr), .rsv_thr(rsv_thr), .sq_thr(sq_thr)
  );

  function automatic int vt(int t); return int'(val_thr[t*CNT_W +: CNT_W]); endfunction
  function automatic int rt(int t); return int'(rsv_thr[t*CNT_W +: CNT_W]); endfunction
  function automatic int st(int t); return int'(sq_thr[t*CNT_W +: CNT_W]);  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clear_in();
    rsv_req = 0; app_req = 0; pull_req = 0; sq_all = 0; sq_one = 0;
  endtask

  // One cycle of requests; outputs are inspected 1 ns after the edge.
  task automatic cyc(logic r, int rtid, logic a, int atid, int tag,
                     logic p, logic sa, logic so, int stid);
    rsv_req = r; rsv_tid = TID_W'(rtid);
    app_req = a; app_tid = TID_W'(atid); app_tag = TAG_W'(tag);
    pull_req = p; sq_all = sa; sq_one = so; sq_tid = TID_W'(stid);
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 out_avail", int'(out_avail), 0);
    chk("R1 totals", int'(val_total) + int'(rsv_total) + int'(sq_total), 0);
  endtask

  task automatic t_reserve_append();
    do_reset();
    cyc(1, 2, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 rsv_total", int'(rsv_total), 1);
    chk("R2 rsv_thr2", rt(2), 1);
    cyc(0, 0, 1, 1, 16'h11, 0, 0, 0, 0);     // no reservation for thread 1
    chk("R3 stray append val_total", int'(val_total), 0);
    chk("R3 stray append out_avail", int'(out_avail), 0);
    cyc(0, 0, 1, 2, 16'h22, 0, 0, 0, 0);
    chk("R3 val_thr2", vt(2), 1);
    chk("R3 rsv_thr2", rt(2), 0);
    chk("R4 out_tag", int'(out_tag), 16'h22);
    chk("R4 out_tid", int'(out_tid), 2);
    chk("R3 out_squashed", int'(out_squashed), 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) cyc(1, i % NT, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 full", int'(full), 1);
    chk("R8 occupancy", int'(occupancy), DEPTH);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 reserve when full", int'(rsv_total), DEPTH);
    chk("R2 rsv_thr1 when full", rt(1), 2);
    cyc(0, 0, 1, 0, 16'h30, 0, 0, 0, 0);
    chk("R8 occupancy after append", int'(occupancy), DEPTH);
    chk("R3 rsv_total", int'(rsv_total), DEPTH - 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 pull val_total", int'(val_total), 0);
    chk("R8 occupancy after pull", int'(occupancy), DEPTH - 1);
    chk("R8 full after pull", int'(full), 0);
  endtask

  task automatic t_empty_pull();
    do_reset();
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 empty pull occupancy", int'(occupancy), 0);
    chk("R4 empty pull avail", int'(out_avail), 0);
    cyc(1, 1, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 empty pull with reserve", int'(rsv_total), 1);
    chk("R4 empty pull sq_total", int'(sq_total), 0);
  endtask

  // Streaming: each cycle reserves, appends the previous reservation and
  // pulls, running far enough to wrap the indices twice.
  task automatic t_stream();
    do_reset();
    for (int k = 0; k < 20; k++) begin
      rsv_req = 1; rsv_tid = TID_W'(k % NT);
      if (k >= 1) begin
        app_req = 1; app_tid = TID_W'((k - 1) % NT); app_tag = TAG_W'(16'h100 + k - 1);
      end
      if (k >= 2) begin
        pull_req = 1;
        chk("R5 order tag", int'(out_tag), 16'h100 + k - 2);
        chk("R5 order tid", int'(out_tid), (k - 2) % NT);
      end
      @(posedge clk); #1;
      clear_in();
    end
    chk("R9 val_total", int'(val_total), 1);
    chk("R9 rsv_total", int'(rsv_total), 1);
    chk("R9 occupancy", int'(occupancy), 2);
  endtask

  task automatic t_squash_all();
    do_reset();
    for (int i = 0; i < NT; i++) cyc(1, i, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 16'h60, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 16'h61, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R6 val_total", int'(val_total), 0);
    chk("R6 sq_total", int'(sq_total), 2);
    chk("R6 rsv_total", int'(rsv_total), 0);
    chk("R6 occupancy", int'(occupancy), 2);
    chk("R6 head squashed", int'(out_squashed), 1);
    chk("R6 sq_thr1", st(1), 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 squashed pull sq_total", int'(sq_total), 1);
    chk("R6 second head squashed", int'(out_squashed), 1);
    chk("R5 second head tag", int'(out_tag), 16'h61);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 drained avail", int'(out_avail), 0);
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 16'h6F, 0, 0, 0, 0);
    chk("R12 fresh entry squashed flag", int'(out_squashed), 0);
    chk("R12 fresh entry tag", int'(out_tag), 16'h6F);
    chk("R12 val_thr3", vt(3), 1);
  endtask

  task automatic t_squash_one();
    do_reset();
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 2, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 16'hA1, 0, 0, 0, 0);
    cyc(0, 0, 1, 2, 16'hB2, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 16'hC1, 0, 0, 0, 0);
    cyc(1, 2, 0, 0, 0, 0, 0, 0, 0);
    // squash thread 1 while also requesting reserve, append and pull
    cyc(1, 0, 1, 2, 16'hEE, 1, 0, 1, 1);
    chk("R7 val_thr1", vt(1), 0);
    chk("R7 sq_thr1", st(1), 2);
    chk("R7 val_thr2 kept", vt(2), 1);
    chk("R10 rsv_thr2 append ignored", rt(2), 1);
    chk("R7 rsv_thr3 kept", rt(3), 1);
    chk("R10 rsv_thr0 reserve ignored", rt(0), 0);
    chk("R10 occupancy pull ignored", int'(occupancy), 5);
    chk("R7 head tag", int'(out_tag), 16'hA1);
    chk("R7 head squashed", int'(out_squashed), 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 live head", int'(out_squashed), 0);
    chk("R5 live head tag", int'(out_tag), 16'hB2);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 val_thr2 after pull", vt(2), 0);
    chk("R7 last head squashed", int'(out_squashed), 1);
    chk("R11 rsv_total", int'(rsv_total), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_reserve_append();
    t_full();
    t_empty_pull();
    t_stream();
    t_squash_all();
    t_squash_one();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule